// File: doc/BRIEF.md
# Oversampled Reader Command Decoder

This block recovers the bytes of a reader-to-card command from a one-bit sample stream. There are four samples for each elementary time unit (ETU). An unmodulated carrier reads as 1 and a modulated carrier reads as 0. The block processes a sample only in a cycle where the sample strobe is high, so the sample rate can be any fraction of the clock rate.

A frame starts with a start-of-frame pattern: a run of low bits followed by a return to high. The block checks the length of the low run against a lower and an upper limit. After that, each character has ten bits: a low start bit, eight data bits sent least significant bit first, and a high stop bit. Every good character produces a one-cycle byte strobe.

An all-zero character is the end-of-frame. It raises a frame-done pulse if the frame carried at least one byte. Malformed traffic raises a one-cycle error pulse and sends the decoder back to hunting for a new frame. Malformed traffic covers an over-long start-of-frame, a gap between characters that is too long, a broken character and a frame longer than the programmed limit. A status output shows when the decoder is locked inside a frame.

Top module: `reader_cmd_decoder`

## Requirements
- R1: After reset, `byte_valid`, `frame_done`, `err_pulse` and `reader_active` are all low, and the decoder is hunting for a start-of-frame.
- R2: The decoder locks when the sample taken at the third sample position of a bit is high and at least 10 low bits preceded it (10, 11 or 12). Each later character is sampled at the third of its four samples. Its bits are shifted in from the top of a 10-bit register. If bit 9 (the stop bit) is 1 and bit 0 (the start bit) is 0, bits 8:1 are presented on `byte_data` with a one-cycle `byte_valid`.
- R3: If the start-of-frame low run is 9 bits or shorter, the decoder does not lock. No byte is produced and `reader_active` stays low.
- R4: A start-of-frame low run that reaches 13 bits gives one `err_pulse`, and the decoder returns to hunting.
- R5: Between characters, and after a start-of-frame, the line may stay high for at most 25 processed samples. The 26th high sample gives one `err_pulse` and returns to hunting.
- R6: An all-zero character after one or more bytes gives one `frame_done` pulse and drops `reader_active`.
- R7: An all-zero character with no byte before it ends the frame silently, with no `frame_done` and no `err_pulse`.
- R8: A character that is neither a data byte nor all zero gives one `err_pulse` and produces no byte.
- R9: When the byte count of a frame reaches `max_len`, that last byte is still delivered. In the same cycle `err_pulse` is raised and the decoder returns to hunting. `max_len` must be at least 1 and stable during a frame.
- R10: `reader_active` is high from the lock on the start-of-frame until the frame ends or is aborted.
- R11: Cycles with `sample_en` low change nothing, whatever `sample_bit` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Qualifies `sample_bit` in this cycle |
| sample_bit | input | 1 | Line sample, 1 = unmodulated |
| max_len | input | LEN_W | Largest number of bytes allowed in one frame |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Received byte |
| frame_done | output | 1 | One-cycle pulse for a completed frame |
| err_pulse | output | 1 | One-cycle pulse when a frame is aborted |
| reader_active | output | 1 | Decoder is locked inside a frame |

## Verification
Random frames exercise the main decode path. Each frame has random bytes and a random length. The start-of-frame low and high runs vary, as does the guard time after each stop bit, and idle cycles with random line values are placed between strobes. A mismatch here separates wrong bit order, wrong sample phase and mishandled enable gating.

Directed frames sit on each limit on both sides:
- a start-of-frame low run of 9 and 10 bits, and of 12 and 13 bits;
- 24 and 25 extra high samples after a stop bit;
- a frame length equal to `max_len` and one below it.

These show whether every comparison uses the right bound. Broken characters, an end-of-frame with no bytes, and an end-of-frame after bytes separate the three outcomes of the character check.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  localparam int CHAR_W = 10;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SOF  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } rcd_state_e;

  typedef enum logic [1:0] {
    CH_BYTE = 2'd0,
    CH_EOF  = 2'd1,
    CH_BAD  = 2'd2
  } rcd_char_e;

  // A character is a byte when framed by a low start and a high stop bit.
  function automatic rcd_char_e classify_char(input logic [CHAR_W-1:0] c);
    if (c[CHAR_W-1] && !c[0]) return CH_BYTE;
    else if (c == '0)         return CH_EOF;
    else                      return CH_BAD;
  endfunction

  function automatic logic [7:0] char_payload(input logic [CHAR_W-1:0] c);
    return c[8:1];
  endfunction

endpackage

// File: rtl/rcd_phase_ctr.sv
module rcd_phase_ctr #(
  parameter int SPB = 4,
  parameter int MID = 2,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  input  logic          wrap_en,
  output logic [PW-1:0] phase_inc,
  output logic          mid_hit
);
  logic [PW-1:0] phase_q;

  assign phase_inc = phase_q + PW'(1);
  assign mid_hit   = adv && (phase_inc == PW'(MID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  phase_q <= '0;
    else if (clr)                                phase_q <= '0;
    else if (adv && wrap_en && phase_inc >= PW'(SPB)) phase_q <= '0;
    else if (adv)                                phase_q <= phase_inc;
  end

  // Inside a bit period the phase never reaches the period length.
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && !clr && adv) |=> (phase_q < PW'(SPB)));
endmodule

// File: rtl/rcd_char_shift.sv
module rcd_char_shift
  import rcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  output logic [CHAR_W-1:0] chr_next
);
  logic [CHAR_W-1:0] chr_q;

  assign chr_next = {bit_in, chr_q[CHAR_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chr_q <= '0;
    else if (clr)   chr_q <= '0;
    else if (shift) chr_q <= chr_next;
  end
endmodule

// File: rtl/rcd_byte_tally.sv
module rcd_byte_tally #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] max_len,
  output logic             at_last,
  output logic             any
);
  logic [LEN_W:0] cnt_q;
  logic [LEN_W:0] cnt_inc;

  assign cnt_inc = cnt_q + (LEN_W+1)'(1);
  assign at_last = cnt_inc >= {1'b0, max_len};
  assign any     = cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_inc;
  end

  // A new byte is only taken while the frame is still below its limit.
  assert_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && $stable(max_len)) |-> (cnt_q < {1'b0, max_len}));
endmodule

// File: rtl/rcd_sync_fsm.sv
module rcd_sync_fsm
  import rcd_pkg::*;
#(
  parameter int SOF_MIN_BITS = 9,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int PW           = 5,
  parameter int BW           = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              sample_bit,
  input  logic              mid_hit,
  input  logic [PW-1:0]     phase_inc,
  input  logic [CHAR_W-1:0] chr_next,
  input  logic              tally_last,
  input  logic              tally_any,
  output rcd_state_e        state,
  output logic              phase_clr,
  output logic              wrap_en,
  output logic              shift_en,
  output logic              shift_clr,
  output logic              tally_clr,
  output logic              tally_inc,
  output logic              byte_fire,
  output logic              frame_fire,
  output logic              err_fire
);
  localparam logic [BW-1:0] SOF_MIN_C = BW'(SOF_MIN_BITS);
  localparam logic [BW-1:0] SOF_MAX_C = BW'(SOF_MAX_BITS);
  localparam logic [BW-1:0] CHAR_C    = BW'(CHAR_W);
  localparam logic [PW-1:0] GAP_C     = PW'(GAP_MAX);

  rcd_state_e    st_q, st_d;
  logic [BW-1:0] bits_q, bits_d, bits_inc;
  logic          sof_lock;  // named event: start-of-frame accepted
  rcd_char_e     kind;

  assign state    = st_q;
  assign bits_inc = bits_q + BW'(1);
  assign kind     = classify_char(chr_next);
  assign wrap_en  = (st_q == ST_SOF) || (st_q == ST_DATA);

  always_comb begin
    st_d       = st_q;
    bits_d     = bits_q;
    phase_clr  = 1'b0;
    shift_en   = 1'b0;
    shift_clr  = 1'b0;
    tally_clr  = 1'b0;
    tally_inc  = 1'b0;
    byte_fire  = 1'b0;
    frame_fire = 1'b0;
    err_fire   = 1'b0;
    sof_lock   = 1'b0;
    if (sample_en) begin
      unique case (st_q)
        ST_HUNT: begin
          phase_clr = 1'b1;
          if (!sample_bit) begin
            st_d      = ST_SOF;
            bits_d    = '0;
            tally_clr = 1'b1;
          end
        end
        ST_SOF: begin
          if (mid_hit) begin
            if (sample_bit) begin
              if (bits_q > SOF_MIN_C) begin
                st_d      = ST_GAP;
                phase_clr = 1'b1;
                sof_lock  = 1'b1;
              end else begin
                st_d = ST_HUNT;
              end
              bits_d = '0;
            end else begin
              bits_d = bits_inc;
              if (bits_inc > SOF_MAX_C) begin
                st_d     = ST_HUNT;
                err_fire = 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (sample_bit) begin
            if (phase_inc > GAP_C) begin
              st_d     = ST_HUNT;
              err_fire = 1'b1;
            end
          end else begin
            st_d      = ST_DATA;
            phase_clr = 1'b1;
            bits_d    = '0;
            shift_clr = 1'b1;
          end
        end
        ST_DATA: begin
          if (mid_hit) begin
            shift_en = 1'b1;
            bits_d   = bits_inc;
            if (bits_inc == CHAR_C) begin
              bits_d = '0;
              unique case (kind)
                CH_BYTE: begin
                  byte_fire = 1'b1;
                  tally_inc = 1'b1;
                  if (tally_last) begin
                    st_d     = ST_HUNT;
                    err_fire = 1'b1;
                  end else begin
                    st_d      = ST_GAP;
                    phase_clr = 1'b1;
                  end
                end
                CH_EOF: begin
                  st_d       = ST_HUNT;
                  frame_fire = tally_any;
                end
                default: begin
                  st_d     = ST_HUNT;
                  err_fire = 1'b1;
                end
              endcase
            end
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      bits_q <= '0;
    end else begin
      st_q   <= st_d;
      bits_q <= bits_d;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(st_q));
  assert_sof_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOF) |-> (bits_q <= SOF_MAX_C));
  assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (phase_inc <= GAP_C + PW'(1)));
  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_lock |=> (st_q == ST_GAP));
endmodule

// File: rtl/reader_cmd_decoder.sv
module reader_cmd_decoder
  import rcd_pkg::*;
#(
  parameter int SPB          = 4,
  parameter int MID_POS      = 2,
  parameter int SOF_MIN_BITS = 9,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int LEN_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             sample_bit,
  input  logic [LEN_W-1:0] max_len,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             frame_done,
  output logic             err_pulse,
  output logic             reader_active
);
  localparam int PW      = $clog2(GAP_MAX + 2);
  localparam int BIT_TOP = (SOF_MAX_BITS > CHAR_W) ? SOF_MAX_BITS : CHAR_W;
  localparam int BW      = $clog2(BIT_TOP + 2);

  rcd_state_e        state;
  logic              phase_clr, wrap_en, mid_hit;
  logic [PW-1:0]     phase_inc;
  logic              shift_en, shift_clr;
  logic [CHAR_W-1:0] chr_next;
  logic              tally_clr, tally_inc, tally_last, tally_any;
  logic              byte_fire, frame_fire, err_fire;

  rcd_phase_ctr #(.SPB(SPB), .MID(MID_POS), .PW(PW)) phase_i (
    .clk(clk), .rst_n(rst_n), .adv(sample_en), .clr(phase_clr),
    .wrap_en(wrap_en), .phase_inc(phase_inc), .mid_hit(mid_hit));

  rcd_char_shift shift_i (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .shift(shift_en),
    .bit_in(sample_bit), .chr_next(chr_next));

  rcd_byte_tally #(.LEN_W(LEN_W)) tally_i (
    .clk(clk), .rst_n(rst_n), .clr(tally_clr), .inc(tally_inc),
    .max_len(max_len), .at_last(tally_last), .any(tally_any));

  rcd_sync_fsm #(
    .SOF_MIN_BITS(SOF_MIN_BITS), .SOF_MAX_BITS(SOF_MAX_BITS),
    .GAP_MAX(GAP_MAX), .PW(PW), .BW(BW)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_bit(sample_bit),
    .mid_hit(mid_hit), .phase_inc(phase_inc), .chr_next(chr_next),
    .tally_last(tally_last), .tally_any(tally_any), .state(state),
    .phase_clr(phase_clr), .wrap_en(wrap_en), .shift_en(shift_en),
    .shift_clr(shift_clr), .tally_clr(tally_clr), .tally_inc(tally_inc),
    .byte_fire(byte_fire), .frame_fire(frame_fire), .err_fire(err_fire));

  assign reader_active = (state == ST_GAP) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      frame_done <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      byte_valid <= byte_fire;
      frame_done <= frame_fire;
      err_pulse  <= err_fire;
      if (byte_fire) byte_data <= char_payload(chr_next);
    end
  end

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !reader_active);
  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !frame_done);
  assert_byte_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(sample_en));
  assert_active_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reader_active) |-> ($past(sample_en) && $past(sample_bit)));
endmodule

// File: tb/reader_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module reader_cmd_decoder_tb_top;
  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sample_en = 1'b0;
  logic             sample_bit = 1'b1;
  logic [LEN_W-1:0] max_len = 9'd16;
  logic             byte_valid, frame_done, err_pulse, reader_active;
  logic [7:0]       byte_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] got_q[$];
  logic [7:0] tx_q[$];
  int n_done = 0, n_err = 0;

  always #2.5 clk = ~clk;

  reader_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_bit(sample_bit),
    .max_len(max_len), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_done(frame_done), .err_pulse(err_pulse), .reader_active(reader_active));

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) got_q.push_back(byte_data);
    if (frame_done) n_done++;
    if (err_pulse)  n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bytes a frame should yield: the length, cut off at the limit.
  function automatic int exp_bytes(input int n, input int lim);
    return (n < lim) ? n : lim;
  endfunction

  // Idle cycles with random line values precede each strobe (R11).
  task automatic send_sample(input logic b);
    int idle = $urandom % 3;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk); sample_en = 1'b0; sample_bit = 1'($urandom % 2);
    end
    @(negedge clk); sample_en = 1'b1; sample_bit = b;
  endtask

  task automatic send_bit(input logic b);
    for (int i = 0; i < 4; i++) send_sample(b);
  endtask

  task automatic send_sof(input int lows, input int highs);
    for (int i = 0; i < lows; i++)  send_bit(1'b0);
    for (int i = 0; i < highs; i++) send_bit(1'b1);
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(stop);
  endtask

  task automatic send_eof();
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    send_bit(1'b1);
  endtask

  task automatic settle();
    @(negedge clk); sample_en = 1'b0; sample_bit = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_case();
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    settle();
    got_q.delete(); tx_q.delete(); n_done = 0; n_err = 0;
  endtask

  task automatic cmp_bytes(input string req, input int exp_n);
    chk(got_q.size() == exp_n, req, got_q.size(), exp_n);
    for (int i = 0; i < exp_n && i < got_q.size(); i++)
      chk(got_q[i] == tx_q[i], req, got_q[i], tx_q[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1443));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!byte_valid && !frame_done && !err_pulse, "R1 pulses", 0, 0);
    chk(!reader_active, "R1 active", reader_active, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!reader_active && !err_pulse, "R1 after release", reader_active, 0);

    // R2/R10/R6: directed frame with the longest accepted SOF
    start_case();
    send_sof(12, 2);
    settle();
    chk(reader_active == 1'b1, "R10 locked after SOF", reader_active, 1);
    tx_q = '{8'h01, 8'h80, 8'hFF};
    foreach (tx_q[i]) send_char(tx_q[i], 1'b1);
    send_eof(); settle();
    cmp_bytes("R2 directed", 3);
    chk(n_done == 1, "R6 frame_done", n_done, 1);
    chk(!reader_active, "R6 active dropped", reader_active, 0);
    chk(n_err == 0, "R2 no error", n_err, 0);

    // R3: SOF of 9 low bits is too short
    start_case();
    send_sof(9, 2); send_char(8'h7E, 1'b1); send_bit(1'b1); settle();
    chk(got_q.size() == 0, "R3 no bytes", got_q.size(), 0);
    chk(!reader_active, "R3 not locked", reader_active, 0);

    // R4: 13 low bits is an error
    start_case();
    send_sof(13, 3); settle();
    chk(n_err == 1, "R4 long SOF error", n_err, 1);
    chk(!reader_active, "R4 hunting", reader_active, 0);

    // R5: 24 extra high samples tolerated
    start_case();
    send_sof(10, 2);
    tx_q = '{8'hA5, 8'h11};
    send_char(tx_q[0], 1'b1);
    for (int i = 0; i < 24; i++) send_sample(1'b1);
    send_char(tx_q[1], 1'b1); send_eof(); settle();
    cmp_bytes("R5 gap 24", 2);
    chk(n_done == 1 && n_err == 0, "R5 gap 24 clean", n_err, 0);

    // R5: 25 extra high samples times out
    start_case();
    send_sof(10, 2);
    tx_q = '{8'h3C};
    send_char(tx_q[0], 1'b1);
    for (int i = 0; i < 25; i++) send_sample(1'b1);
    send_bit(1'b1); settle();
    cmp_bytes("R5 gap 25", 1);
    chk(n_err == 1 && n_done == 0, "R5 timeout error", n_err, 1);
    chk(!reader_active, "R5 hunting", reader_active, 0);

    // R7: EOF with no bytes
    start_case();
    send_sof(11, 2); send_eof(); settle();
    chk(n_done == 0 && n_err == 0, "R7 silent", n_done + n_err, 0);
    chk(!reader_active, "R7 hunting", reader_active, 0);

    // R8: low stop bit with nonzero data
    start_case();
    send_sof(10, 2); send_char(8'h5A, 1'b0); send_bit(1'b1); settle();
    chk(got_q.size() == 0, "R8 no byte", got_q.size(), 0);
    chk(n_err == 1, "R8 error", n_err, 1);

    // R9: frame reaching the limit aborts after the last byte
    max_len = 9'd3;
    start_case();
    send_sof(10, 2);
    tx_q = '{8'h12, 8'h34, 8'h56};
    foreach (tx_q[i]) send_char(tx_q[i], 1'b1);
    send_bit(1'b1); settle();
    cmp_bytes("R9 at limit", exp_bytes(3, 3));
    chk(n_err == 1 && n_done == 0, "R9 abort error", n_err, 1);
    chk(!reader_active, "R9 hunting", reader_active, 0);
    max_len = 9'd4;
    start_case();
    send_sof(10, 2);
    tx_q = '{8'h9A, 8'hBC, 8'hDE};
    foreach (tx_q[i]) send_char(tx_q[i], 1'b1);
    send_eof(); settle();
    cmp_bytes("R9 below limit", exp_bytes(3, 4));
    chk(n_done == 1 && n_err == 0, "R9 completes", n_done, 1);

    // R2/R11: random frames with random strobe gaps
    max_len = 9'd16;
    for (int f = 0; f < 20; f++) begin
      int n = 1 + ($urandom % 8);
      start_case();
      for (int i = 0; i < n; i++) tx_q.push_back(8'($urandom));
      send_sof(10 + ($urandom % 3), 2 + ($urandom % 2));
      foreach (tx_q[i]) begin
        send_char(tx_q[i], 1'b1);
        for (int g = 0; g < int'($urandom % 5); g++) send_bit(1'b1);
      end
      send_eof(); settle();
      cmp_bytes("R2 R11 random", exp_bytes(n, 16));
      chk(n_done == 1 && n_err == 0, "R6 random done", n_done, 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule